// File: doc/BRIEF.md
# Two-Window Timed Sequence Monitor

This block watches a stream of two-bit symbols that arrives at a fixed time step. It accepts the ordered pattern a, b, c, d. Two timing windows apply to the pattern. The symbol c must arrive soon enough after a, and the symbol d must arrive late enough after b. The block tracks progress through four positions, numbered 0 to 3. It keeps two dwell counters, and each counter runs only while the monitor sits in its own group of positions. The two groups overlap at position 2.

On each step the next position is chosen from three things: the current position, the symbol, and the full set of counters that have reached their limits. Because all expired counters are considered together, two counters that expire at once never conflict. When a complete pattern is accepted, the block raises a single-cycle completion pulse. The surrounding logic supplies one step strobe per time unit. Symbols may be marked as absent. An absent symbol still lets time advance.

Top module: `timed_seq_monitor`

## Requirements
- R1: A synchronous reset puts the monitor in position 0 with done_o low and both dwell counters at zero.
- R2: A clock edge with step_en low changes neither the position, nor the counters, and it leaves done_o low.
- R3: In position 0, a step with valid symbol a (code 0) moves to position 1. Any other step stays in position 0.
- R4: In position 1, a step with valid symbol b (code 1) moves to position 2 whatever the counters hold. Any other step stays in position 1.
- R5: In position 2, a step with valid symbol c (code 2) moves to position 3 only while the early window counter is below T1_LIMIT. Once that counter has reached the limit, c stays in position 2. Other steps stay in position 2.
- R6: In position 3, a step with valid symbol d (code 3) returns to position 0 only once the late window counter has reached T2_LIMIT. Otherwise every step stays in position 3.
- R7: Each counter advances by one, saturating at its limit, on a step where both the current and the next position lie in its group. On any other step it clears to zero. The early window group is positions {1,2}. The late window group is positions {2,3}.
- R8: A step with sym_valid_i low acts as a non-matching symbol. The position holds, and the counters follow R7.
- R9: done_o is high for exactly the one cycle after the step that takes position 3 to position 0, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | One time step when high |
| sym_i | input | 2 | Symbol code: a=0, b=1, c=2, d=3 |
| sym_valid_i | input | 1 | Symbol present on this step |
| state_o | output | 2 | Current position, 0 to 3 |
| done_o | output | 1 | Pulse after an accepted pattern |

## Verification
The hardest outcomes to reach from the ports are these:
- d being accepted in position 3.
- c being refused in position 2.

Both depend on counter values that cannot be seen. They appear only after particular numbers of dwell steps in overlapping groups. The bench drives every sequence of six steps from reset, with each step drawn from the four symbols or an absent symbol. This covers every arrival time of c and d within the windows. Directed runs then hold the monitor for long stretches in positions 2 and 3 to exercise counter saturation, and gate the strobe off to show that an edge without a step has no effect.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    typedef enum logic [1:0] {
        POS_IDLE  = 2'd0,
        POS_SAW_A = 2'd1,
        POS_SAW_B = 2'd2,
        POS_SAW_C = 2'd3
    } tsm_pos_e;

    typedef enum logic [1:0] {
        SYM_A = 2'd0,
        SYM_B = 2'd1,
        SYM_C = 2'd2,
        SYM_D = 2'd3
    } tsm_sym_e;

    localparam int NUM_WINDOWS = 2;

    // Position-group masks, one bit per position
    localparam logic [3:0] EARLY_GROUP = 4'b0110;
    localparam logic [3:0] LATE_GROUP  = 4'b1100;

    function automatic logic pos_in_group(logic [3:0] group, tsm_pos_e pos);
        return group[2'(pos)];
    endfunction

endpackage

// File: rtl/tsm_dwell_timer.sv
module tsm_dwell_timer
    import tsm_pkg::*;
#(
    parameter int         LIMIT = 2,
    parameter logic [3:0] GROUP = 4'b0110
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     step_en,
    input  tsm_pos_e cur_pos,
    input  tsm_pos_e nxt_pos,
    output logic     expired_o
);
    localparam int         CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_W = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } dwell_t;

    dwell_t dw_d, dw_q;

    always_comb begin
        dw_d = dw_q;
        if (step_en) begin
            if (pos_in_group(GROUP, cur_pos) && pos_in_group(GROUP, nxt_pos)) begin
                if (dw_q.cnt < LIM_W) begin
                    dw_d.cnt = dw_q.cnt + 1'b1;
                end
            end else begin
                dw_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dw_q <= '0;
        end else begin
            dw_q <= dw_d;
        end
    end

    assign expired_o = (dw_q.cnt >= LIM_W);

endmodule

// File: rtl/tsm_step_logic.sv
module tsm_step_logic
    import tsm_pkg::*;
(
    input  tsm_pos_e               cur_pos,
    input  logic [1:0]             sym,
    input  logic                   sym_valid,
    input  logic [NUM_WINDOWS-1:0] expired,
    output tsm_pos_e               nxt_pos,
    output logic                   accept
);
    logic hit_a, hit_b, hit_c, hit_d;

    always_comb begin
        hit_a = sym_valid && (sym == SYM_A);
        hit_b = sym_valid && (sym == SYM_B);
        hit_c = sym_valid && (sym == SYM_C);
        hit_d = sym_valid && (sym == SYM_D);

        nxt_pos = cur_pos;
        accept  = 1'b0;
        unique case (cur_pos)
            POS_IDLE: begin
                if (hit_a) nxt_pos = POS_SAW_A;
            end
            POS_SAW_A: begin
                if (hit_b) nxt_pos = POS_SAW_B;
            end
            POS_SAW_B: begin
                if (hit_c && !expired[0]) nxt_pos = POS_SAW_C;
            end
            POS_SAW_C: begin
                if (hit_d && expired[1]) begin
                    nxt_pos = POS_IDLE;
                    accept  = 1'b1;
                end
            end
            default: nxt_pos = POS_IDLE;
        endcase
    end

endmodule

// File: rtl/timed_seq_monitor.sv
module timed_seq_monitor
    import tsm_pkg::*;
#(
    parameter int T1_LIMIT = 2,
    parameter int T2_LIMIT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step_en,
    input  logic [1:0] sym_i,
    input  logic       sym_valid_i,
    output logic [1:0] state_o,
    output logic       done_o
);
    typedef struct packed {
        tsm_pos_e pos;
        logic     done;
    } mon_t;

    mon_t mon_d, mon_q;

    tsm_pos_e               nxt_pos;
    logic                   accept;
    logic [NUM_WINDOWS-1:0] expired;

    for (genvar g = 0; g < NUM_WINDOWS; g++) begin : g_window
        localparam int         LIM = (g == 0) ? T1_LIMIT : T2_LIMIT;
        localparam logic [3:0] GRP = (g == 0) ? EARLY_GROUP : LATE_GROUP;

        tsm_dwell_timer #(
            .LIMIT (LIM),
            .GROUP (GRP)
        ) u_timer (
            .clk       (clk),
            .rst       (rst),
            .step_en   (step_en),
            .cur_pos   (mon_q.pos),
            .nxt_pos   (nxt_pos),
            .expired_o (expired[g])
        );
    end

    tsm_step_logic u_step (
        .cur_pos   (mon_q.pos),
        .sym       (sym_i),
        .sym_valid (sym_valid_i),
        .expired   (expired),
        .nxt_pos   (nxt_pos),
        .accept    (accept)
    );

    always_comb begin
        mon_d      = mon_q;
        mon_d.done = 1'b0;
        if (step_en) begin
            mon_d.pos  = nxt_pos;
            mon_d.done = accept;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_q.pos  <= POS_IDLE;
            mon_q.done <= 1'b0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign state_o = mon_q.pos;
    assign done_o  = mon_q.done;

endmodule

// File: rtl/timed_seq_monitor_sva.sv
module timed_seq_monitor_sva (
    input logic       clk,
    input logic       rst,
    input logic       step_en,
    input logic [1:0] sym_i,
    input logic       sym_valid_i,
    input logic [1:0] state_o,
    input logic       done_o
);
    // R2: no step, no change
    assert_hold_no_step_R2: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(state_o) && !done_o));

    // R3: leaving position 0 needs symbol a
    assert_idle_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && !(step_en && sym_valid_i && sym_i == 2'd0)) |=> state_o == 2'd0);

    // R4: b in position 1 always advances
    assert_b_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (step_en && state_o == 2'd1 && sym_valid_i && sym_i == 2'd1) |=> state_o == 2'd2);

    // R5: c in position 2 goes to 2 or 3 only
    assert_c_target_R5: assert property (@(posedge clk) disable iff (rst)
        (step_en && state_o == 2'd2 && sym_valid_i && sym_i == 2'd2) |=> (state_o == 2'd2 || state_o == 2'd3));

    // R6: position 3 is left only on a stepped d
    assert_late_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3 && !(step_en && sym_valid_i && sym_i == 2'd3)) |=> state_o == 2'd3);

    // R8: an absent symbol holds the position
    assert_absent_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (step_en && !sym_valid_i) |=> $stable(state_o));

    // R9: done follows a 3 -> 0 move and lasts one cycle
    assert_done_origin_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (state_o == 2'd0 && $past(state_o) == 2'd3));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind timed_seq_monitor timed_seq_monitor_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .step_en     (step_en),
    .sym_i       (sym_i),
    .sym_valid_i (sym_valid_i),
    .state_o     (state_o),
    .done_o      (done_o)
);

// File: tb/timed_seq_monitor_tb.sv
module timed_seq_monitor_tb;
    localparam int L1 = 2;
    localparam int L2 = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic [1:0] sym_i = 2'd0;
    logic       sym_valid_i = 1'b0;
    logic [1:0] state_o;
    logic       done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int m_pos, m_t1, m_t2;
    bit m_done;

    always #10 clk = ~clk;

    timed_seq_monitor #(.T1_LIMIT(L1), .T2_LIMIT(L2)) u_dut (
        .clk(clk), .rst(rst), .step_en(step_en), .sym_i(sym_i),
        .sym_valid_i(sym_valid_i), .state_o(state_o), .done_o(done_o)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit in_early(int p); return (p == 1 || p == 2); endfunction
    function automatic bit in_late(int p);  return (p == 2 || p == 3); endfunction

    task automatic model_step(bit en, bit v, int s);
        int nxt;
        bit e1, e2;
        m_done = 0;
        if (!en) return;
        e1 = (m_t1 >= L1);
        e2 = (m_t2 >= L2);
        nxt = m_pos;
        case (m_pos)
            0: if (v && s == 0) nxt = 1;
            1: if (v && s == 1) nxt = 2;
            2: if (v && s == 2 && !e1) nxt = 3;
            default: if (v && s == 3 && e2) begin nxt = 0; m_done = 1; end
        endcase
        m_t1 = (in_early(m_pos) && in_early(nxt)) ? ((m_t1 < L1) ? m_t1 + 1 : m_t1) : 0;
        m_t2 = (in_late(m_pos) && in_late(nxt)) ? ((m_t2 < L2) ? m_t2 + 1 : m_t2) : 0;
        m_pos = nxt;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step_en = 1'b0;
        sym_valid_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pos = 0; m_t1 = 0; m_t2 = 0; m_done = 0;
        check("R1 position after reset", int'(state_o), 0);
        check("R1 done after reset", int'(done_o), 0);
    endtask

    task automatic apply(bit en, bit v, int s);
        string tag;
        if (!en)      tag = "R2 ungated edge";
        else if (!v)  tag = "R8 absent symbol";
        else case (m_pos)
            0: tag = "R3 position 0";
            1: tag = "R4 position 1";
            2: tag = "R5 R7 position 2";
            default: tag = "R6 R7 position 3";
        endcase
        step_en = en;
        sym_valid_i = v;
        sym_i = 2'(s);
        model_step(en, v, s);
        @(posedge clk);
        @(negedge clk);
        step_en = 1'b0;
        check(tag, int'(state_o), m_pos);
        check("R9 done pulse", int'(done_o), int'(m_done));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Every six-step sequence from reset; option 4 is an absent symbol
        for (int code = 0; code < 15625; code++) begin
            int c;
            c = code;
            do_reset();
            for (int k = 0; k < 6; k++) begin
                int o;
                o = c % 5;
                c = c / 5;
                if (o == 4) apply(1, 0, 0);
                else        apply(1, 1, o);
            end
        end

        // R7: early window saturates, late c refused for a long time
        do_reset();
        apply(1, 1, 0); apply(1, 1, 1);
        for (int k = 0; k < 12; k++) apply(1, 0, 0);
        apply(1, 1, 2);
        check("R5 R7 saturated early window refuses c", int'(state_o), 2);

        // R7: late window saturates and still accepts d
        do_reset();
        apply(1, 1, 0); apply(1, 1, 1); apply(1, 1, 2);
        for (int k = 0; k < 20; k++) apply(1, 0, 0);
        apply(1, 1, 3);
        check("R6 R7 saturated late window accepts d", int'(state_o), 0);
        check("R9 done after saturated accept", int'(done_o), 1);
        apply(0, 0, 0);
        check("R9 done falls after one cycle", int'(done_o), 0);

        // R2: ungated edges with would-be matching symbols in every position
        do_reset();
        apply(0, 1, 0);
        apply(1, 1, 0);
        apply(0, 1, 1);
        apply(1, 1, 1);
        apply(0, 1, 2);
        apply(1, 1, 2);
        for (int k = 0; k < 5; k++) apply(0, 1, 3);
        apply(1, 1, 3);
        apply(0, 1, 3);
        apply(1, 1, 3);
        check("R2 R6 accept after ungated wait", int'(state_o), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule